// File: doc/BRIEF.md
# Tick-Driven Compare Timer with Staged Register Writes

This peripheral keeps a 24-bit up-counter that advances on each pulse of a `tick` input while counting is enabled. Two compare channels watch the counter. Either compare value can raise its own match flag. Channel 0 can also act as the period limit, so the counter wraps to zero after reaching it. Overflow and the two match events land in a three-bit flag bank. Software sets flag bits through a write-one-to-set word and clears them through a write-one-to-clear word. An enable mask gates the flags onto a single `irq` line. A debug-halt input stops the count unless the debug-run control bit is set.

Writes to the control word and to the two compare words are not applied at once. Each of these three words is owned by a small sync FSM with three states. **IDLE** means nothing is pending. **HELD** means a write is parked because the freeze bit is set. **WAIT** means a write is counting down `SYNC_TICKS` tick pulses before it takes effect. The transitions are:

- *IDLE→WAIT*: a write while unfrozen.
- *IDLE→HELD*: a write while frozen.
- *HELD→WAIT*: the freeze bit is found clear.
- *WAIT→HELD*: the freeze bit is found set.
- *WAIT→WAIT*: a new write restarts the countdown.
- *WAIT→IDLE*: commit on the last tick pulse.

Reads of these words return the committed value. A busy word shows which of the three FSMs is not in IDLE. Setting freeze, writing several words and then clearing freeze makes all the parked writes commit on the same tick.

Top module: `cmp_tick_timer`

Word addresses: 0 control, 1 counter, 2 compare 0, 3 compare 1, 4 flags (read-only), 5 flag set, 6 flag clear, 7 interrupt mask, 8 freeze, 9 busy (read-only). Flag, set, clear and mask words use bit 0 = overflow, bit 1 = compare 0 match, bit 2 = compare 1 match.

## Requirements
- R1: After reset every mapped word reads zero and `irq` is low.
- R2: With control bit 0 set, the counter rises by one on each edge where `tick` is high. Otherwise it holds. A write to word 1 loads the counter at that edge (low 24 bits) and wins over a tick in the same cycle.
- R3: With control bit 2 clear, a tick at 0xFFFFFF gives 0 and sets flag bit 0.
- R4: With control bit 2 set, a tick while the counter equals compare 0 gives 0 and sets flag bit 0.
- R5: Flag bit 1 (bit 2) is set by the tick whose new counter value equals compare 0 (compare 1).
- R6: Writing word 5 sets the flag bits written as one. Writing word 6 clears them. Zero bits leave flags alone. A counter event in the same cycle as a clear leaves its flag set. Writes to word 4 have no effect.
- R7: `irq` is high exactly when some flag bit and the same bit of word 7 are both one.
- R8: A write to word 0, 2 or 3 while unfrozen commits at the third `tick` pulse after the write edge. Busy bit 0, 1 or 2 (word 9) is high from the write until the commit. The word reads its old value until then.
- R9: While freeze (word 8 bit 0) is set, written words do not commit and their busy bits stay high. After freeze is cleared, all parked writes commit together after three further tick pulses.
- R10: While `dbg_halt` is high and control bit 1 is clear, the counter holds. With control bit 1 set it keeps counting.
- R11: Unused upper bits of every word read zero, and addresses 10 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count/sync pulse, one per edge when high |
| dbg_halt | input | 1 | Debug halt request |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked OR of the flags |

## Verification
A sync FSM stuck in HELD or WAIT shows on the busy word at the next read. It also shows as a stale control or compare value on the following tick pulses. A miscounted countdown moves the commit tick, so the counter starts, stops or wraps one tick early or late, and that is visible on the counter word within a few ticks. A wrong wrap or match comparison leaves a flag that differs from the reference model in the cycle of the event. Through the mask, that same cycle also shows on `irq`.

// File: rtl/cmpt_pkg.sv
`timescale 1ns/1ps
package cmpt_pkg;
    // word addresses; the order is the software-visible map
    localparam int RA_CTRL  = 0;
    localparam int RA_COUNT = 1;
    localparam int RA_CMP0  = 2;
    localparam int RA_CMP1  = 3;
    localparam int RA_FLAG  = 4;
    localparam int RA_FSET  = 5;
    localparam int RA_FCLR  = 6;
    localparam int RA_MASK  = 7;
    localparam int RA_FRZ   = 8;
    localparam int RA_BUSY  = 9;

    // control bits
    localparam int CB_EN  = 0;
    localparam int CB_DBG = 1;
    localparam int CB_TOP = 2;
    localparam int CTRL_W = 3;

    // flag bits
    localparam int FB_OVF = 0;
    localparam int FB_C0  = 1;
    localparam int FB_C1  = 2;
    localparam int NFLAG  = 3;

    typedef enum logic [1:0] {
        SY_IDLE = 2'd0,
        SY_HELD = 2'd1,
        SY_WAIT = 2'd2
    } sync_st_e;
endpackage

// File: rtl/cmpt_sync_chan.sv
`timescale 1ns/1ps
module cmpt_sync_chan
    import cmpt_pkg::*;
#(
    parameter int W     = 24,
    parameter int TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         freeze,
    input  logic         tick,
    output logic [W-1:0] live_q,
    output logic         busy
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    sync_st_e       st_q, st_d;
    logic [CW-1:0]  n_q, n_d;
    logic [W-1:0]   pend_q;
    logic           commit;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SY_IDLE: if (wr) st_d = freeze ? SY_HELD : SY_WAIT;
            SY_HELD: begin
                if (wr)           st_d = freeze ? SY_HELD : SY_WAIT;
                else if (!freeze) st_d = SY_WAIT;
            end
            SY_WAIT: begin
                if (wr)                     st_d = freeze ? SY_HELD : SY_WAIT;
                else if (freeze)            st_d = SY_HELD;
                else if (tick && n_q == LAST) st_d = SY_IDLE;
            end
            default: st_d = SY_IDLE;
        endcase
    end

    // outputs of the FSM
    always_comb begin
        busy   = (st_q != SY_IDLE);
        commit = (st_q == SY_WAIT) && !wr && !freeze && tick && (n_q == LAST);
        if (st_d == SY_WAIT && st_q != SY_WAIT) n_d = '0;
        else if (wr)                            n_d = '0;
        else if (st_q == SY_WAIT && tick && !freeze && n_q != LAST) n_d = n_q + 1'b1;
        else                                    n_d = n_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SY_IDLE;
            n_q    <= '0;
            pend_q <= '0;
            live_q <= '0;
        end else begin
            st_q <= st_d;
            n_q  <= n_d;
            if (wr)     pend_q <= wdata;
            if (commit) live_q <= pend_q;
        end
    end

    assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> $stable(live_q));
    assert_commit_from_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_q) |-> $past(st_q == SY_WAIT && tick));
endmodule

// File: rtl/cmpt_counter.sv
`timescale 1ns/1ps
module cmpt_counter
    import cmpt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             top_en,
    input  logic [CNT_W-1:0] cmp0_val,
    input  logic [CNT_W-1:0] cmp1_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [NFLAG-1:0] evt
);
    logic             adv, wrap;
    logic [CNT_W-1:0] step_cnt, cnt_d;

    always_comb begin
        adv      = tick && run && !load;
        wrap     = (cnt_q == '1) || (top_en && cnt_q == cmp0_val);
        step_cnt = wrap ? '0 : cnt_q + 1'b1;
        cnt_d    = load ? load_val : (adv ? step_cnt : cnt_q);
        evt         = '0;
        evt[FB_OVF] = adv && wrap;
        evt[FB_C0]  = adv && (step_cnt == cmp0_val);
        evt[FB_C1]  = adv && (step_cnt == cmp1_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_max_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !load && cnt_q == '1) |=> (cnt_q == '0));
    assert_top_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !load && top_en && cnt_q == cmp0_val) |=> (cnt_q == '0));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && run) && !load) |=> $stable(cnt_q));
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/cmpt_flags.sv
`timescale 1ns/1ps
module cmpt_flags
    import cmpt_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic         mask_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] mask_q,
    output logic         irq
);
    logic [N-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (set_wr) flags_d = flags_d | wbits;
        if (clr_wr) flags_d = flags_d & ~wbits;
        flags_d = flags_d | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            mask_q  <= '0;
        end else begin
            flags_q <= flags_d;
            if (mask_wr) mask_q <= wbits;
        end
    end

    assign irq = |(flags_q & mask_q);

    assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((flags_q & $past(wbits)) == $past(wbits)));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((flags_q & $past(wbits)) == ($past(evt) & $past(wbits))));
endmodule

// File: rtl/cmp_tick_timer.sv
`timescale 1ns/1ps
module cmp_tick_timer
    import cmpt_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              dbg_halt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int NCMP = 2;

    logic              freeze_q;
    logic [CTRL_W-1:0] ctrl_live;
    logic              ctrl_busy;
    logic [CNT_W-1:0]  cmp_live [NCMP];
    logic [NCMP-1:0]   cmp_busy;
    logic [CNT_W-1:0]  cnt_q;
    logic [NFLAG-1:0]  evt, flags_q, mask_q;
    logic              run;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-1:CNT_W];

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int ra);
        return a == ADDR_W'(ra);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              freeze_q <= 1'b0;
        else if (bus_we && hit(bus_addr, RA_FRZ)) freeze_q <= bus_wdata[0];
    end

    cmpt_sync_chan #(.W(CTRL_W), .TICKS(SYNC_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_we && hit(bus_addr, RA_CTRL)),
        .wdata(bus_wdata[CTRL_W-1:0]),
        .freeze(freeze_q), .tick(tick),
        .live_q(ctrl_live), .busy(ctrl_busy)
    );

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        cmpt_sync_chan #(.W(CNT_W), .TICKS(SYNC_TICKS)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr(bus_we && hit(bus_addr, RA_CMP0 + k)),
            .wdata(bus_wdata[CNT_W-1:0]),
            .freeze(freeze_q), .tick(tick),
            .live_q(cmp_live[k]), .busy(cmp_busy[k])
        );
    end

    assign run = ctrl_live[CB_EN] && (!dbg_halt || ctrl_live[CB_DBG]);

    cmpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .top_en(ctrl_live[CB_TOP]),
        .cmp0_val(cmp_live[0]), .cmp1_val(cmp_live[1]),
        .load(bus_we && hit(bus_addr, RA_COUNT)),
        .load_val(bus_wdata[CNT_W-1:0]),
        .cnt_q(cnt_q), .evt(evt)
    );

    cmpt_flags #(.N(NFLAG)) u_flg (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .set_wr(bus_we && hit(bus_addr, RA_FSET)),
        .clr_wr(bus_we && hit(bus_addr, RA_FCLR)),
        .mask_wr(bus_we && hit(bus_addr, RA_MASK)),
        .wbits(bus_wdata[NFLAG-1:0]),
        .flags_q(flags_q), .mask_q(mask_q), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit(bus_addr, RA_CTRL))  bus_rdata = DATA_W'(ctrl_live);
        if (hit(bus_addr, RA_COUNT)) bus_rdata = DATA_W'(cnt_q);
        if (hit(bus_addr, RA_CMP0))  bus_rdata = DATA_W'(cmp_live[0]);
        if (hit(bus_addr, RA_CMP1))  bus_rdata = DATA_W'(cmp_live[1]);
        if (hit(bus_addr, RA_FLAG))  bus_rdata = DATA_W'(flags_q);
        if (hit(bus_addr, RA_MASK))  bus_rdata = DATA_W'(mask_q);
        if (hit(bus_addr, RA_FRZ))   bus_rdata = DATA_W'(freeze_q);
        if (hit(bus_addr, RA_BUSY))  bus_rdata = DATA_W'({cmp_busy, ctrl_busy});
    end

    assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (mask_q != '0));
endmodule

// File: tb/sim_cmp_tick_timer.sv
`timescale 1ns/1ps
module sim_cmp_tick_timer;
    logic        clk = 0, rst_n = 0, tick = 0, dbg_halt = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit started = 0;

    always #10 clk = ~clk;

    cmp_tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_halt(dbg_halt),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference model
    bit [23:0] m_live [3];
    bit [23:0] m_pend [3];
    int        m_st   [3];
    int        m_n    [3];
    bit [23:0] m_cnt;
    bit [2:0]  m_flg, m_ien;
    bit        m_frz;

    function automatic int chan_addr(int i);
        return (i == 0) ? 0 : i + 1;
    endfunction

    always @(posedge clk) begin : model
        bit [2:0]  ev, c;
        bit [23:0] nc, wv;
        bit        run, wrap;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_live[i] = 0; m_pend[i] = 0; m_st[i] = 0; m_n[i] = 0;
            end
            m_cnt = 0; m_flg = 0; m_ien = 0; m_frz = 0;
        end else begin
            c   = m_live[0][2:0];
            run = c[0] && (!dbg_halt || c[1]);
            ev  = 0;
            nc  = m_cnt;
            if (bus_we && bus_addr == 1) nc = bus_wdata[23:0];
            else if (tick && run) begin
                wrap  = (m_cnt == 24'hFFFFFF) || (c[2] && m_cnt == m_live[1]);
                nc    = wrap ? 24'd0 : m_cnt + 24'd1;
                ev[0] = wrap;
                ev[1] = (nc == m_live[1]);
                ev[2] = (nc == m_live[2]);
            end
            m_cnt = nc;
            if (bus_we && bus_addr == 5) m_flg = m_flg | bus_wdata[2:0];
            if (bus_we && bus_addr == 6) m_flg = m_flg & ~bus_wdata[2:0];
            m_flg = m_flg | ev;
            if (bus_we && bus_addr == 7) m_ien = bus_wdata[2:0];
            for (int i = 0; i < 3; i++) begin
                wv = (i == 0) ? {21'd0, bus_wdata[2:0]} : bus_wdata[23:0];
                if (bus_we && bus_addr == chan_addr(i)) begin
                    m_pend[i] = wv; m_st[i] = m_frz ? 1 : 2; m_n[i] = 0;
                end else if (m_st[i] == 1 && !m_frz) begin
                    m_st[i] = 2; m_n[i] = 0;
                end else if (m_st[i] == 2 && m_frz) begin
                    m_st[i] = 1;
                end else if (m_st[i] == 2 && tick) begin
                    if (m_n[i] == 2) begin m_live[i] = m_pend[i]; m_st[i] = 0; end
                    else m_n[i] = m_n[i] + 1;
                end
            end
            if (bus_we && bus_addr == 8) m_frz = bus_wdata[0];
        end
    end

    function automatic bit [31:0] model_read(bit [3:0] a);
        case (a)
            0: return {29'd0, m_live[0][2:0]};
            1: return {8'd0, m_cnt};
            2: return {8'd0, m_live[1]};
            3: return {8'd0, m_live[2]};
            4: return {29'd0, m_flg};
            7: return {29'd0, m_ien};
            8: return {31'd0, m_frz};
            9: return {29'd0, m_st[2] != 0, m_st[1] != 0, m_st[0] != 0};
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(bit [3:0] a);
        case (a)
            0, 2, 3, 9: return "R8";
            1:          return "R2";
            4, 5, 6:    return "R6";
            7:          return "R7";
            8:          return "R9";
            default:    return "R11";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
            chk("R7", {31'd0, irq}, {31'd0, |(m_flg & m_ien)});
        end
    end

    task automatic wr(bit [3:0] a, bit [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(posedge clk); #1;
        bus_we = 0;
    endtask

    task automatic ticks(int n);
        tick = 1;
        repeat (n) @(posedge clk);
        #1 tick = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_rd(bit [3:0] a, bit [31:0] exp, string tag);
        bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        started = 1;
        // R1 / R11: reset values and unmapped words
        for (int a = 0; a < 16; a++)
            expect_rd(a[3:0], 0, (a < 10) ? "R1" : "R11");
        @(negedge clk); chk("R1", {31'd0, irq}, 0);

        // R11: upper write bits dropped on the counter
        wr(1, 32'hFFFF_FFFD);
        expect_rd(1, 32'h00FF_FFFD, "R11");
        wr(7, 7);
        // R8: staged control write
        wr(0, 1);
        expect_rd(9, 1, "R8");
        expect_rd(0, 0, "R8");
        ticks(3);
        expect_rd(9, 0, "R8");
        expect_rd(0, 1, "R8");
        expect_rd(1, 32'hFF_FFFD, "R8");
        // R2 counting, R3 wrap at the maximum
        ticks(2);
        expect_rd(1, 32'hFF_FFFF, "R2");
        expect_rd(4, 0, "R5");
        ticks(1);
        expect_rd(1, 0, "R3");
        expect_rd(4, 7, "R3");
        chk("R7", {31'd0, irq}, 1);
        // R6: set / clear / read-only flag word
        wr(6, 7);
        expect_rd(4, 0, "R6");
        chk("R7", {31'd0, irq}, 0);
        wr(4, 7);
        expect_rd(4, 0, "R6");
        wr(5, 2);
        expect_rd(4, 2, "R6");
        wr(7, 1);
        expect_rd(7, 1, "R7");
        chk("R7", {31'd0, irq}, 0);
        wr(6, 2);

        // R9: freeze parks writes, then commits together
        wr(8, 1);
        wr(2, 5);
        wr(0, 5);
        ticks(6);
        expect_rd(9, 3, "R9");
        expect_rd(2, 0, "R9");
        expect_rd(1, 6, "R9");
        wr(8, 0);
        idle(1);
        ticks(3);
        expect_rd(9, 0, "R9");
        expect_rd(0, 5, "R9");
        expect_rd(2, 5, "R9");
        expect_rd(1, 9, "R9");
        // R5 compare match, R4 top wrap
        wr(1, 3);
        ticks(2);
        expect_rd(4, 2, "R5");
        ticks(1);
        expect_rd(1, 0, "R4");
        expect_rd(4, 7, "R4");
        // R6: event beats clear in the same cycle
        wr(6, 7);
        wr(1, 4);
        tick = 1;
        wr(6, 2);
        tick = 0;
        expect_rd(4, 2, "R6");
        expect_rd(1, 5, "R6");

        // R10: debug halt
        dbg_halt = 1;
        ticks(3);
        expect_rd(1, 5, "R10");
        wr(0, 7);
        ticks(3);
        expect_rd(9, 0, "R10");
        expect_rd(1, 5, "R10");
        ticks(2);
        expect_rd(1, 1, "R10");
        dbg_halt = 0;

        // R2: load wins over a tick
        tick = 1;
        wr(1, 32'h10);
        tick = 0;
        expect_rd(1, 32'h10, "R2");

        // mixed traffic checked by the model every cycle
        for (int i = 0; i < 400; i++) begin
            tick = (i % 3) != 0;
            bus_addr = 4'(i % 13);
            if (i % 61 == 7) wr(3, 32'(i / 4));
            else if (i % 89 == 11) wr(5, 1);
            else if (i % 97 == 50) wr(6, 7);
            else idle(1);
        end
        tick = 0;
        idle(2);
        summary();
        $finish;
    end
endmodule